// File: doc/BRIEF.md
# Dual-Controller USB Port Ownership Router

This block sits between a set of physical USB ports and two host controllers: a companion controller that handles full-speed and low-speed traffic, and a high-speed controller. For each port it decides which controller is the owner. Only the owner drives the port's transmit data and output enable, and only the owner receives the port's data. Ownership depends on a global configure flag, on one owner bit per port and on a debug mode that reserves one port for the high-speed controller.

The block is the only logic that sees the raw physical connect state of each port. Each controller gets a connect status built from that state and gated by ownership, plus a one-clock change pulse. When software hands a connected port from one controller to the other, the new owner sees a connect and the old owner sees a disconnect, even though nothing changed at the port. Overcurrent indications are not switched and go to both controllers.

Ownership changes are registered. On the cycle in which a port's owner changes, that port's output enable is held low so that the two controllers never drive the port at the same time.

Top module: `usb_port_router`

## Requirements
- R1: While `cfg_flag_i` is 0, the companion controller owns every port: its connect status follows the physical state, and the high-speed connect status is 0 (debug port excepted, see R3).
- R2: While `cfg_flag_i` is 1, the high-speed controller owns port i when owner bit i is 0, and the companion controller owns it when owner bit i is 1. The port's transmit data and output enable come from the owning controller.
- R3: While `dbg_mode_i` is 1, port 0 is owned by the high-speed controller whatever the configure flag and owner bit 0 hold.
- R4: The controller that does not own a port sees that port's connect status as 0, and its receive output for that port is 0. The owner's receive output equals `port_rx_i`.
- R5: `oc_i` is passed unchanged and in the same cycle to both `fs_oc_o` and `hs_oc_o`.
- R6: Each connect status output is registered: after a clock edge it equals the physical connect input sampled at that edge, ANDed with that controller's ownership decided at the same edge.
- R7: A controller's change pulse for a port (`fs_csc_o`/`hs_csc_o`) is 1 for exactly the cycle after its connect status changed, whether the cause was a physical change or an ownership change. Handing a connected port from high-speed to companion gives a companion connect and a high-speed disconnect, each with a pulse.
- R8: An ownership change takes effect at the first clock edge that samples the new control inputs. For the one cycle after that edge, `port_oe_o` of that port is 0 even if both controllers request to drive.
- R9: Owner bit i reads back on `own_rd_o[i]` (1 = companion). While `cfg_flag_i` is 0 every bit reads 1, and an owner write (`own_wr_i` with `own_wdata_i`) is ignored; while the flag is 1 a write stores `own_wdata_i`.
- R10: While `rst_n` is 0 and until the first edge after its release, `port_oe_o` is all 0; after reset the connect statuses and change pulses are 0 and the owner bits read all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_flag_i | input | 1 | Global configure flag; 1 lets the high-speed controller own ports |
| dbg_mode_i | input | 1 | Debug mode; reserves port 0 for the high-speed controller |
| own_wr_i | input | 1 | Write strobe for the owner bits |
| own_wdata_i | input | 6 | New owner bits, bit i for port i (1 = companion) |
| own_rd_o | output | 6 | Owner bits as read back |
| phys_conn_i | input | 6 | Raw physical connect state per port |
| oc_i | input | 6 | Overcurrent indication per port |
| port_rx_i | input | 6 | Received data per port |
| port_tx_o | output | 6 | Transmit data to each port from its owner |
| port_oe_o | output | 6 | Output enable to each port from its owner |
| fs_tx_i | input | 6 | Companion controller transmit data per port |
| fs_oe_i | input | 6 | Companion controller output enable per port |
| fs_rx_o | output | 6 | Received data to the companion controller |
| fs_conn_o | output | 6 | Connect status seen by the companion controller |
| fs_csc_o | output | 6 | Connect change pulse to the companion controller |
| fs_oc_o | output | 6 | Overcurrent to the companion controller |
| hs_tx_i | input | 6 | High-speed controller transmit data per port |
| hs_oe_i | input | 6 | High-speed controller output enable per port |
| hs_rx_o | output | 6 | Received data to the high-speed controller |
| hs_conn_o | output | 6 | Connect status seen by the high-speed controller |
| hs_csc_o | output | 6 | Connect change pulse to the high-speed controller |
| hs_oc_o | output | 6 | Overcurrent to the high-speed controller |

## Verification
The ownership decision is driven through a sequence of flag, debug and owner-write patterns with all ports connected or only some connected, so that the connect split between the two controllers shows which of the configure flag, the owner bits and the debug override won on each port. A write made while the flag is 0 and a debug override on a port whose owner bit says companion separate a correct priority order from a merely plausible one. A handover of one connected port checks the paired connect and disconnect pulses and the blanked output enable cycle. A physical connect on another port checks that a change pulse reaches only the owner, and fixed transmit, receive and overcurrent patterns check the data paths.

// File: rtl/usb_router_pkg.sv
package usb_router_pkg;

  // Ownership decision: 1 = high-speed controller, 0 = companion.
  // Debug override first, then the configure flag, then the owner bit.
  function automatic logic hs_owner(input logic cfg_flag,
                                    input logic dbg_mode,
                                    input logic owner_bit,
                                    input logic is_dbg_port);
    if (is_dbg_port && dbg_mode) return 1'b1;
    if (!cfg_flag)               return 1'b0;
    return !owner_bit;
  endfunction

  // A controller's view of a port: connected only when it owns the port.
  function automatic logic seen_conn(input logic phys, input logic owns);
    return phys & owns;
  endfunction

endpackage

// File: rtl/usb_owner_ctl.sv
module usb_owner_ctl #(
  parameter int N_PORTS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_i,
  input  logic               wr_i,
  input  logic [N_PORTS-1:0] wdata_i,
  output logic [N_PORTS-1:0] own_next_o,
  output logic [N_PORTS-1:0] own_rd_o
);
  localparam logic [N_PORTS-1:0] ALL_FS = '1;

  logic [N_PORTS-1:0] own_q;

  // Next owner bits: forced to companion while the flag is low.
  always_comb begin
    if (!cfg_i)     own_next_o = ALL_FS;
    else if (wr_i)  own_next_o = wdata_i;
    else            own_next_o = own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= ALL_FS;
    else        own_q <= own_next_o;
  end

  assign own_rd_o = cfg_i ? own_q : ALL_FS;

  AST_OWN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_i) |-> (own_q == ALL_FS)); // R9

  AST_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_i) && !$past(wr_i)) |-> (own_q == $past(own_rd_o))); // R9

endmodule

// File: rtl/usb_port_slice.sv
module usb_port_slice
  import usb_router_pkg::*;
#(
  parameter bit IS_DBG_PORT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_i,
  input  logic dbg_i,
  input  logic own_next_i,
  input  logic phys_i,
  input  logic rx_i,
  input  logic fs_tx_i,
  input  logic fs_oe_i,
  input  logic hs_tx_i,
  input  logic hs_oe_i,
  output logic tx_o,
  output logic oe_o,
  output logic fs_rx_o,
  output logic hs_rx_o,
  output logic fs_conn_o,
  output logic hs_conn_o,
  output logic fs_csc_o,
  output logic hs_csc_o,
  output logic hs_own_o
);
  logic hs_own_d, hs_own_q;
  logic guard_q;
  logic fs_conn_d, hs_conn_d;
  logic fs_conn_q, hs_conn_q;
  logic fs_csc_q, hs_csc_q;
  logic own_flip;

  assign hs_own_d  = hs_owner(cfg_i, dbg_i, own_next_i, IS_DBG_PORT);
  assign own_flip  = hs_own_d ^ hs_own_q;
  assign fs_conn_d = seen_conn(phys_i, !hs_own_d);
  assign hs_conn_d = seen_conn(phys_i, hs_own_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_own_q  <= 1'b0;
      guard_q   <= 1'b1;
      fs_conn_q <= 1'b0;
      hs_conn_q <= 1'b0;
      fs_csc_q  <= 1'b0;
      hs_csc_q  <= 1'b0;
    end else begin
      hs_own_q  <= hs_own_d;
      guard_q   <= own_flip;
      fs_conn_q <= fs_conn_d;
      hs_conn_q <= hs_conn_d;
      fs_csc_q  <= fs_conn_d ^ fs_conn_q;
      hs_csc_q  <= hs_conn_d ^ hs_conn_q;
    end
  end

  // Data path: owner drives, blanked on the cycle after a switch.
  assign tx_o      = hs_own_q ? hs_tx_i : fs_tx_i;
  assign oe_o      = !guard_q && (hs_own_q ? hs_oe_i : fs_oe_i);
  assign fs_rx_o   = rx_i & !hs_own_q;
  assign hs_rx_o   = rx_i & hs_own_q;
  assign fs_conn_o = fs_conn_q;
  assign hs_conn_o = hs_conn_q;
  assign fs_csc_o  = fs_csc_q;
  assign hs_csc_o  = hs_csc_q;
  assign hs_own_o  = hs_own_q;

  AST_NONOWNER_FS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_own_q |-> !fs_conn_q); // R4

  AST_NONOWNER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_own_q |-> !hs_conn_q); // R4

  AST_CONN_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_conn_q || hs_conn_q) |-> $past(phys_i)); // R6

  AST_SWITCH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_own_q != $past(hs_own_q)) |-> !oe_o); // R8

  AST_CSC_FS: assert property (@(posedge clk) disable iff (!rst_n)
    fs_csc_q |-> (fs_conn_q != $past(fs_conn_q))); // R7

  AST_CSC_HS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_csc_q |-> (hs_conn_q != $past(hs_conn_q))); // R7

  generate
    if (IS_DBG_PORT) begin : g_dbg
      AST_DBG_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dbg_i) |-> hs_own_q); // R3
    end
  endgenerate

endmodule

// File: rtl/usb_port_router.sv
module usb_port_router #(
  parameter int N_PORTS  = 6,
  parameter int DBG_PORT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_flag_i,
  input  logic               dbg_mode_i,
  input  logic               own_wr_i,
  input  logic [N_PORTS-1:0] own_wdata_i,
  output logic [N_PORTS-1:0] own_rd_o,
  input  logic [N_PORTS-1:0] phys_conn_i,
  input  logic [N_PORTS-1:0] oc_i,
  input  logic [N_PORTS-1:0] port_rx_i,
  output logic [N_PORTS-1:0] port_tx_o,
  output logic [N_PORTS-1:0] port_oe_o,
  input  logic [N_PORTS-1:0] fs_tx_i,
  input  logic [N_PORTS-1:0] fs_oe_i,
  output logic [N_PORTS-1:0] fs_rx_o,
  output logic [N_PORTS-1:0] fs_conn_o,
  output logic [N_PORTS-1:0] fs_csc_o,
  output logic [N_PORTS-1:0] fs_oc_o,
  input  logic [N_PORTS-1:0] hs_tx_i,
  input  logic [N_PORTS-1:0] hs_oe_i,
  output logic [N_PORTS-1:0] hs_rx_o,
  output logic [N_PORTS-1:0] hs_conn_o,
  output logic [N_PORTS-1:0] hs_csc_o,
  output logic [N_PORTS-1:0] hs_oc_o
);
  logic [N_PORTS-1:0] own_next;
  logic [N_PORTS-1:0] hs_own;

  usb_owner_ctl #(.N_PORTS(N_PORTS)) u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg_flag_i),
    .wr_i       (own_wr_i),
    .wdata_i    (own_wdata_i),
    .own_next_o (own_next),
    .own_rd_o   (own_rd_o)
  );

  generate
    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
      usb_port_slice #(.IS_DBG_PORT(i == DBG_PORT)) u_slice (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg_flag_i),
        .dbg_i      (dbg_mode_i),
        .own_next_i (own_next[i]),
        .phys_i     (phys_conn_i[i]),
        .rx_i       (port_rx_i[i]),
        .fs_tx_i    (fs_tx_i[i]),
        .fs_oe_i    (fs_oe_i[i]),
        .hs_tx_i    (hs_tx_i[i]),
        .hs_oe_i    (hs_oe_i[i]),
        .tx_o       (port_tx_o[i]),
        .oe_o       (port_oe_o[i]),
        .fs_rx_o    (fs_rx_o[i]),
        .hs_rx_o    (hs_rx_o[i]),
        .fs_conn_o  (fs_conn_o[i]),
        .hs_conn_o  (hs_conn_o[i]),
        .fs_csc_o   (fs_csc_o[i]),
        .hs_csc_o   (hs_csc_o[i]),
        .hs_own_o   (hs_own[i])
      );
    end
  endgenerate

  // Overcurrent is not switched: both controllers record it.
  assign fs_oc_o = oc_i;
  assign hs_oc_o = oc_i;

  AST_OC_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    fs_oc_o == hs_oc_o); // R5

  AST_NO_DOUBLE_CONN: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_conn_o & hs_conn_o) == '0); // R4

  AST_FS_ALL_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_flag_i) && !$past(dbg_mode_i)) |-> (hs_own == '0)); // R1

endmodule

// File: tb/usb_port_router_test.sv
module usb_port_router_test;
  localparam int CLK_P = 10;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg = 1'b0, dbg = 1'b0, wr = 1'b0;
  logic [NP-1:0] wdata = '0, phys = '0, oc = '0, prx = '0;
  logic [NP-1:0] fs_tx = '0, fs_oe = '0, hs_tx = '0, hs_oe = '0;
  logic [NP-1:0] own_rd, ptx, poe, fs_rx, fs_conn, fs_csc, fs_oc;
  logic [NP-1:0] hs_rx, hs_conn, hs_csc, hs_oc;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  usb_port_router #(.N_PORTS(NP), .DBG_PORT(0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_flag_i(cfg), .dbg_mode_i(dbg),
    .own_wr_i(wr), .own_wdata_i(wdata), .own_rd_o(own_rd),
    .phys_conn_i(phys), .oc_i(oc), .port_rx_i(prx),
    .port_tx_o(ptx), .port_oe_o(poe),
    .fs_tx_i(fs_tx), .fs_oe_i(fs_oe), .fs_rx_o(fs_rx), .fs_conn_o(fs_conn),
    .fs_csc_o(fs_csc), .fs_oc_o(fs_oc),
    .hs_tx_i(hs_tx), .hs_oe_i(hs_oe), .hs_rx_o(hs_rx), .hs_conn_o(hs_conn),
    .hs_csc_o(hs_csc), .hs_oc_o(hs_oc)
  );

  // Row: cfg, dbg, wr, wdata, phys, expected fs_conn, expected hs_conn
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 6'b000000, 6'b111111, 6'b111111, 6'b000000},
    {1'b0, 1'b0, 1'b1, 6'b000000, 6'b111111, 6'b111111, 6'b000000},
    {1'b1, 1'b0, 1'b0, 6'b000000, 6'b111111, 6'b111111, 6'b000000},
    {1'b1, 1'b0, 1'b1, 6'b000000, 6'b111111, 6'b000000, 6'b111111},
    {1'b1, 1'b0, 1'b1, 6'b101010, 6'b110011, 6'b100010, 6'b010001},
    {1'b1, 1'b1, 1'b1, 6'b000001, 6'b001111, 6'b000000, 6'b001111},
    {1'b0, 1'b1, 1'b0, 6'b000000, 6'b111111, 6'b111110, 6'b000001},
    {1'b0, 1'b0, 1'b0, 6'b000000, 6'b000110, 6'b000110, 6'b000000}
  };

  task automatic chk(input string tag, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Reset: no port driven even when both controllers request it (R10)
    fs_oe = '1; hs_oe = '1;
    repeat (3) @(negedge clk);
    chk("R10 oe in reset", poe, 6'b000000);
    rst_n = 1'b1;
    #1;
    chk("R10 oe first cycle", poe, 6'b000000);
    chk("R10 owner readback", own_rd, 6'b111111);
    chk("R10 fs_conn", fs_conn, 6'b000000);
    chk("R10 hs_csc", hs_csc, 6'b000000);
    tick();
    chk("R1 oe follows companion", poe, 6'b111111);

    // Table walk: ownership split seen through connect status (R1 R2 R3 R6 R9)
    foreach (VEC[k]) begin
      {cfg, dbg, wr, wdata, phys} = VEC[k][26:12];
      tick();
      chk($sformatf("R6 row%0d fs_conn", k), fs_conn, VEC[k][11:6]);
      chk($sformatf("R2 row%0d hs_conn", k), hs_conn, VEC[k][5:0]);
    end
    wr = 1'b0; dbg = 1'b0;

    // Handover setup: all ports high-speed owned, port 2 connected
    cfg = 1'b1; wr = 1'b1; wdata = 6'b000000; phys = 6'b000100;
    tick();
    wr = 1'b0;
    tick();
    tick();
    chk("R7 hs sees port2", hs_conn, 6'b000100);
    chk("R7 no stale pulse", hs_csc | fs_csc, 6'b000000);

    // Handover of port 2 to the companion (R7 R8)
    fs_oe = '1; hs_oe = '1;
    wr = 1'b1; wdata = 6'b000100;
    tick();
    wr = 1'b0;
    chk("R7 fs connect", fs_conn, 6'b000100);
    chk("R7 hs disconnect", hs_conn, 6'b000000);
    chk("R7 fs pulse", fs_csc, 6'b000100);
    chk("R7 hs pulse", hs_csc, 6'b000100);
    chk("R8 blank cycle", poe, 6'b111011);
    tick();
    chk("R7 pulse one cycle", fs_csc | hs_csc, 6'b000000);
    chk("R8 oe restored", poe, 6'b111111);

    // Transmit mux and receive demux (R2 R4)
    fs_tx = 6'b000000; hs_tx = 6'b111111; prx = 6'b111111;
    #1;
    chk("R2 tx from owner", ptx, 6'b111011);
    chk("R4 fs rx", fs_rx, 6'b000100);
    chk("R4 hs rx", hs_rx, 6'b111011);
    fs_oe = 6'b000000; hs_oe = 6'b001000;
    #1;
    chk("R2 oe from owner", poe, 6'b001000);

    // Overcurrent fan-out (R5)
    oc = 6'b100101;
    #1;
    chk("R5 fs oc", fs_oc, 6'b100101);
    chk("R5 hs oc", hs_oc, 6'b100101);

    // Physical connect on a high-speed port pulses only its owner (R7)
    phys = 6'b001100;
    tick();
    chk("R7 hs phys pulse", hs_csc, 6'b001000);
    chk("R7 fs no pulse", fs_csc, 6'b000000);

    // Owner readback and ignored writes (R9)
    chk("R9 readback", own_rd, 6'b000100);
    cfg = 1'b0;
    #1;
    chk("R9 reads ones", own_rd, 6'b111111);
    wr = 1'b1; wdata = 6'b000000;
    tick();
    wr = 1'b0;
    cfg = 1'b1;
    #1;
    chk("R9 write ignored", own_rd, 6'b111111);
    chk("R1 flag low all companion", hs_conn, 6'b000000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule